// File: doc/BRIEF.md
# Global Interrupt Aggregator with Programmable Output Pin

This block collects eight interrupt sources for a multifunction peripheral into one interrupt pin toward a host processor. Seven sources are single-cycle event pulses: five from the touch sample queue and touch detector, one from error reporting and one from current measurement. The eighth is the already-aggregated GPIO interrupt level. Software enables sources, reads a pending register to find the cause, and clears causes by writing ones to an acknowledge register. The GPIO cause is not latched here. It mirrors the GPIO level, and software clears it at the GPIO block.

The pin can be set as open-drain or push-pull, and as active-low or active-high. The block also holds the system control register, which carries the subsystem enables, a standby flag and a self-clearing soft reset. Registers are reached over a simple 8-bit write strobe and address bus with a combinational read port.

Top module: `irq_hub`

## Requirements
- R1: Address 0x00 always reads 0x7B. After reset, addresses 0x40, 0x41, 0x42 and 0x08 read 0x00 (with gpio_irq_i low) and the pin is released (irq_oe_o = 0).
- R2: Cause bit positions are fixed: 7 queue overflow, 6 queue full, 5 queue threshold, 4 queue not empty, 3 touch detect, 2 error, 1 measurement, 0 GPIO. Input evt_i[k] feeds pending bit k.
- R3: Pending bit k (k = 1..7) is set by a pulse on evt_i[k] only while enable bit k at 0x42 is 1. The set bit reads at 0x08 from the cycle after the pulse.
- R4: Writing to 0x44 clears each pending bit k (k = 1..7) whose data bit is 1 and leaves the others unchanged. If an enabled event and its acknowledge arrive in the same cycle, the bit stays set.
- R5: Pending bit 0 reads the present gpio_irq_i level. Writing 1 to bit 0 of 0x44 has no effect on it.
- R6: The interrupt is asserted while (pending AND enable) is nonzero. Clearing an enable bit removes its cause from the pin but keeps the pending bit.
- R7: At 0x41, bit 0 selects push-pull (1) or open-drain (0), and bit 1 selects active-high (1) or active-low (0). Push-pull drives irq_oe_o = 1 with irq_do_o at the pin level. Open-drain drives irq_oe_o = 1 and irq_do_o = 0 only when the pin level is low, and otherwise releases the pin (irq_oe_o = 0).
- R8: At 0x40, bits 6 (standby), 3 (alternate GPIO), 2 (measurement enable), 1 (touch enable) and 0 (GPIO enable) are writable, read back and drive their outputs. Bits 5 and 4 read 0.
- R9: A write to 0x40 with bit 7 set returns every register, including pending, to its reset value at that clock edge. Bit 7 always reads 0.
- R10: Writes to 0x00 and 0x08 change nothing. Reads of 0x44 and of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| evt_i | input | 7 | Event pulses for cause bits 7..1 |
| gpio_irq_i | input | 1 | Aggregated GPIO interrupt level |
| standby_o | output | 1 | Standby flag |
| alt_gpio_o | output | 1 | Alternate GPIO enable |
| meas_en_o | output | 1 | Measurement enable |
| touch_en_o | output | 1 | Touch enable |
| gpio_en_o | output | 1 | GPIO enable |
| irq_oe_o | output | 1 | Interrupt pin output enable |
| irq_do_o | output | 1 | Interrupt pin output data |

## Verification
Events are pulsed one bit at a time to pin down the bit order. The same pulse is repeated with its enable off and then on, which separates gated latching from ungated latching. Acknowledge patterns with mixed ones and zeros, and an acknowledge that collides with a new event, show whether the clear is per bit and whether the set wins. All four pin configurations are driven with the interrupt both active and idle, so a polarity swap cannot pass for a drive-type swap. Soft reset and writes to read-only addresses are applied over non-default state, so that a missed clear or a stray write shows at the read port.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam logic [7:0] ADR_ID   = 8'h00;
  localparam logic [7:0] ADR_PEND = 8'h08;
  localparam logic [7:0] ADR_SYS  = 8'h40;
  localparam logic [7:0] ADR_PIN  = 8'h41;
  localparam logic [7:0] ADR_EN   = 8'h42;
  localparam logic [7:0] ADR_ACK  = 8'h44;

  localparam int SYS_SRST  = 7;
  localparam int SYS_STBY  = 6;
  localparam int SYS_ALT   = 3;
  localparam int SYS_MEAS  = 2;
  localparam int SYS_TOUCH = 1;
  localparam int SYS_GPIO  = 0;
  localparam logic [7:0] SYS_WMASK = 8'h4F;

  localparam int PIN_PP  = 0;
  localparam int PIN_POL = 1;
  localparam int PIN_W   = 2;
endpackage

// File: rtl/irq_hub_regs.sv
module irq_hub_regs
  import irq_hub_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic              srst_o,
  output logic [DW-1:0]     sys_o,
  output logic [PIN_W-1:0]  pin_cfg_o,
  output logic [DW-1:0]     en_o
);
  logic [DW-1:0]    sys_q, en_q;
  logic [PIN_W-1:0] pin_q;

  assign srst_o = we_i && (addr_i == AW'(ADR_SYS)) && wdata_i[SYS_SRST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sys_q <= '0;
      en_q  <= '0;
      pin_q <= '0;
    end else if (srst_o) begin
      sys_q <= '0;
      en_q  <= '0;
      pin_q <= '0;
    end else if (we_i) begin
      if (addr_i == AW'(ADR_SYS)) sys_q <= wdata_i & DW'(SYS_WMASK);
      if (addr_i == AW'(ADR_PIN)) pin_q <= wdata_i[PIN_W-1:0];
      if (addr_i == AW'(ADR_EN))  en_q  <= wdata_i;
    end
  end

  assign sys_o     = sys_q;
  assign en_o      = en_q;
  assign pin_cfg_o = pin_q;

  AST_SRST_DEFAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_o |=> (sys_o == '0 && en_o == '0 && pin_cfg_o == '0)); // R9
  AST_SRST_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_o[SYS_SRST]); // R9
endmodule

// File: rtl/irq_hub_pend.sv
module irq_hub_pend #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [N-1:1] en_i,
  input  logic [N-1:1] evt_i,
  input  logic [N-1:1] ack_i,
  output logic [N-1:1] pend_o
);
  logic [N-1:1] pend_q;

  for (genvar k = 1; k < N; k++) begin : g_bit
    logic set;
    assign set = evt_i[k] && en_i[k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        pend_q[k] <= 1'b0;
      else if (clr_i)     pend_q[k] <= 1'b0;
      else if (set)       pend_q[k] <= 1'b1;   // set beats a same-cycle ack
      else if (ack_i[k])  pend_q[k] <= 1'b0;
    end

    AST_SET_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q[k] && !$past(pend_q[k])) |-> $past(evt_i[k] && en_i[k])); // R3
    AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i[k] && !(evt_i[k] && en_i[k])) |=> !pend_q[k]); // R4
    AST_EVT_BEATS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i[k] && evt_i[k] && en_i[k] && !clr_i) |=> pend_q[k]); // R4
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_hub_pin.sv
module irq_hub_pin (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic push_pull_i,
  input  logic act_high_i,
  output logic oe_o,
  output logic do_o
);
  logic level;

  assign level = act_high_i ? active_i : !active_i;

  always_comb begin
    if (push_pull_i) begin
      oe_o = 1'b1;
      do_o = level;
    end else begin
      oe_o = !level;   // open-drain: drive low only
      do_o = 1'b0;
    end
  end

  AST_PP_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_pull_i |-> oe_o); // R7
  AST_OD_NEVER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_pull_i && oe_o) |-> !do_o); // R7
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int          AW      = 8,
  parameter int          DW      = 8,
  parameter logic [7:0]  CHIP_ID = 8'h7B
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:1] evt_i,
  input  logic          gpio_irq_i,
  output logic          standby_o,
  output logic          alt_gpio_o,
  output logic          meas_en_o,
  output logic          touch_en_o,
  output logic          gpio_en_o,
  output logic          irq_oe_o,
  output logic          irq_do_o
);
  logic             srst;
  logic [DW-1:0]    sys, en, pend_all;
  logic [PIN_W-1:0] pin_cfg;
  logic [DW-1:1]    ack, pend;
  logic             active;

  irq_hub_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .srst_o(srst), .sys_o(sys), .pin_cfg_o(pin_cfg), .en_o(en)
  );

  assign ack = (we_i && addr_i == AW'(ADR_ACK)) ? wdata_i[DW-1:1] : '0;

  irq_hub_pend #(.N(DW)) u_pend (
    .clk_i, .rst_ni, .clr_i(srst),
    .en_i(en[DW-1:1]), .evt_i, .ack_i(ack), .pend_o(pend)
  );

  assign pend_all = {pend, gpio_irq_i};
  assign active   = |(pend_all & en);

  irq_hub_pin u_pin (
    .clk_i, .rst_ni, .active_i(active),
    .push_pull_i(pin_cfg[PIN_PP]), .act_high_i(pin_cfg[PIN_POL]),
    .oe_o(irq_oe_o), .do_o(irq_do_o)
  );

  assign standby_o  = sys[SYS_STBY];
  assign alt_gpio_o = sys[SYS_ALT];
  assign meas_en_o  = sys[SYS_MEAS];
  assign touch_en_o = sys[SYS_TOUCH];
  assign gpio_en_o  = sys[SYS_GPIO];

  always_comb begin
    unique case (addr_i)
      AW'(ADR_ID):   rdata_o = DW'(CHIP_ID);
      AW'(ADR_SYS):  rdata_o = sys;
      AW'(ADR_PIN):  rdata_o = DW'(pin_cfg);
      AW'(ADR_EN):   rdata_o = en;
      AW'(ADR_PEND): rdata_o = pend_all;
      default:       rdata_o = '0;
    endcase
  end

  AST_IDLE_NOT_ASSERTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en == '0) |-> (pin_cfg[PIN_PP] ? (irq_do_o == !pin_cfg[PIN_POL]) : (irq_oe_o == pin_cfg[PIN_POL]))); // R6
  AST_GPIO_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == AW'(ADR_PEND)) |-> (rdata_o[0] == gpio_irq_i)); // R5
endmodule

// File: tb/irq_hub_test.sv
module irq_hub_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic [7:1] evt = '0;
  logic       gpio = 1'b0;
  logic       stby, alt, meas, touch, gen, oe, dout;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  irq_hub uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .evt_i(evt), .gpio_irq_i(gpio),
    .standby_o(stby), .alt_gpio_o(alt), .meas_en_o(meas), .touch_en_o(touch),
    .gpio_en_o(gen), .irq_oe_o(oe), .irq_do_o(dout)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [7:0] exp);
    @(negedge clk); addr = a; #1;
    chk(req, rdata, exp);
  endtask

  task automatic pulse(logic [7:1] m);
    @(negedge clk); evt = m;
    @(negedge clk); evt = '0;
  endtask

  task automatic pin_chk(string req, logic exp_oe, logic exp_do);
    @(negedge clk); #1;
    chk(req, {6'd0, oe, oe ? dout : 1'b0}, {6'd0, exp_oe, exp_do});
  endtask

  task automatic t_reset();
    rd_chk("R1 id", 8'h00, 8'h7B);
    rd_chk("R1 sys", 8'h40, 8'h00);
    rd_chk("R1 pin", 8'h41, 8'h00);
    rd_chk("R1 en", 8'h42, 8'h00);
    rd_chk("R1 pend", 8'h08, 8'h00);
    pin_chk("R1 released", 1'b0, 1'b0);
  endtask

  task automatic t_sysctl();
    wr(8'h40, 8'h7F);
    rd_chk("R8 sys readback", 8'h40, 8'h4F);
    chk("R8 outputs", {3'd0, stby, alt, meas, touch, gen}, 8'h1F);
    wr(8'h40, 8'h05);
    rd_chk("R8 sys partial", 8'h40, 8'h05);
    chk("R8 outputs partial", {3'd0, stby, alt, meas, touch, gen}, 8'h05);
  endtask

  task automatic t_enable_gate();
    wr(8'h42, 8'h00);
    pulse(7'b0010000);
    rd_chk("R3 disabled event", 8'h08, 8'h00);
    wr(8'h42, 8'h20);
    pulse(7'b0010000);
    rd_chk("R3 enabled event", 8'h08, 8'h20);
    wr(8'h44, 8'hFF);
    wr(8'h42, 8'hFE);
    for (int k = 1; k < 8; k++) begin
      pulse(7'(1 << (k - 1)));
      rd_chk($sformatf("R2 bit %0d", k), 8'h08, 8'(1 << k));
      wr(8'h44, 8'(1 << k));
    end
    rd_chk("R2 all cleared", 8'h08, 8'h00);
  endtask

  task automatic t_ack();
    wr(8'h42, 8'hFE);
    pulse(7'b1010000);
    rd_chk("R4 before ack", 8'h08, 8'hA0);
    wr(8'h44, 8'h20);
    rd_chk("R4 single ack", 8'h08, 8'h80);
    @(negedge clk); we = 1'b1; addr = 8'h44; wdata = 8'h84; evt = 7'b1000010;
    @(negedge clk); we = 1'b0; evt = '0;
    rd_chk("R4 ack vs event", 8'h08, 8'h84);
    wr(8'h44, 8'h84);
    rd_chk("R4 clear rest", 8'h08, 8'h00);
    wr(8'h42, 8'h00);
  endtask

  task automatic t_gpio();
    gpio = 1'b1;
    rd_chk("R5 mirror high", 8'h08, 8'h01);
    wr(8'h44, 8'h01);
    rd_chk("R5 ack ignored", 8'h08, 8'h01);
    gpio = 1'b0;
    rd_chk("R5 mirror low", 8'h08, 8'h00);
  endtask

  task automatic t_pin();
    wr(8'h42, 8'h01);
    gpio = 1'b1;
    wr(8'h41, 8'h00);
    pin_chk("R7 od low active", 1'b1, 1'b0);
    wr(8'h41, 8'h02);
    pin_chk("R7 od high active", 1'b0, 1'b0);
    gpio = 1'b0;
    pin_chk("R7 od high idle", 1'b1, 1'b0);
    wr(8'h41, 8'h00);
    pin_chk("R7 od low idle", 1'b0, 1'b0);
    wr(8'h41, 8'h01);
    pin_chk("R7 pp low idle", 1'b1, 1'b1);
    gpio = 1'b1;
    pin_chk("R7 pp low active", 1'b1, 1'b0);
    wr(8'h41, 8'h03);
    pin_chk("R7 pp high active", 1'b1, 1'b1);
    gpio = 1'b0;
    wr(8'h42, 8'h00);
  endtask

  task automatic t_mask();
    wr(8'h41, 8'h03);
    wr(8'h42, 8'h08);
    pulse(7'b0000100);
    pin_chk("R6 asserted", 1'b1, 1'b1);
    wr(8'h42, 8'h00);
    pin_chk("R6 masked", 1'b1, 1'b0);
    rd_chk("R6 pending kept", 8'h08, 8'h08);
  endtask

  task automatic t_srst();
    wr(8'h42, 8'h0C);
    wr(8'h40, 8'h47);
    wr(8'h40, 8'hC7);
    rd_chk("R9 sys", 8'h40, 8'h00);
    rd_chk("R9 en", 8'h42, 8'h00);
    rd_chk("R9 pin", 8'h41, 8'h00);
    rd_chk("R9 pend", 8'h08, 8'h00);
    pin_chk("R9 released", 1'b0, 1'b0);
  endtask

  task automatic t_readonly();
    wr(8'h42, 8'h40);
    pulse(7'b0100000);
    wr(8'h08, 8'h00);
    rd_chk("R10 pend write", 8'h08, 8'h40);
    wr(8'h00, 8'h00);
    rd_chk("R10 id write", 8'h00, 8'h7B);
    rd_chk("R10 ack reads 0", 8'h44, 8'h00);
    rd_chk("R10 unmapped", 8'h99, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sysctl();
    t_enable_gate();
    t_ack();
    t_gpio();
    t_pin();
    t_mask();
    t_srst();
    t_readonly();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule